// File: doc/BRIEF.md
# CEC Receive Acceptance and Error-Bit Policy

This block sits beside a CEC receiver and makes the per-frame decisions that the bit-level logic cannot make alone. When the receiver presents the header byte of a new frame, the block compares the 4-bit destination in the header's low nibble against a one-hot mask of owned logical addresses. From that match and the listening mode it decides whether the frame is taken in and whether a positive acknowledge is driven. While the frame lasts, it turns error-detect pulses from the bit-timing checkers into a request to drive an error bit on the line and, for rising errors, a request to end the reception.

The error-bit decision is layered. Frames sent to an owned address follow per-error enables. Broadcast frames follow a single suppression setting that overrides those enables. Frames taken in only because full listening is on never disturb the bus. Bit sampling and the timing detectors themselves live outside this block.

Top module: `cec_rx_policy`

## Requirements
- R1: After reset, and in the cycle after any cycle with `rst` high, `accept`, `drive_ack`, `drive_errbit` and `stop_rx` are all 0.
- R2: A header whose destination `hdr_byte[3:0]` is a value d in 0..14 with `own_mask[d]` set gives `accept`=1 and `drive_ack`=1 from the cycle after `hdr_valid`. Several mask bits may be set at once.
- R3: A header with destination 0xF (broadcast) gives `accept`=1 whatever the mask and the listening mode. `drive_ack` stays 0, because on broadcast a low acknowledge slot means rejection.
- R4: With `listen_all`=0, a header to an unowned destination gives `accept`=0 and `drive_ack`=0. Error pulses that follow it produce neither `drive_errbit` nor `stop_rx`.
- R5: With `listen_all`=1, a header to an unowned destination gives `accept`=1 and `drive_ack`=0. No error pulse during that frame produces `drive_errbit`.
- R6: `accept` and `drive_ack` hold until a `frame_end` pulse and are 0 in the cycle after it.
- R7: A rising error during an accepted frame pulses `stop_rx` for one cycle and clears `accept` in that same cycle only when `cfg_stop_on_rise`=1. With `cfg_stop_on_rise`=0 it has no effect on any output.
- R8: For a frame to an owned, non-broadcast address, a rising error pulses `drive_errbit` only when both `cfg_rise_errbit` and `cfg_stop_on_rise` are 1.
- R9: For a frame to an owned, non-broadcast address, a long-period error pulses `drive_errbit` exactly when `cfg_long_errbit`=1, and it never ends the reception.
- R10: For a broadcast frame, a long-period error, or a rising error with `cfg_stop_on_rise`=1, pulses `drive_errbit` exactly when `cfg_bcast_quiet`=0, whatever the two per-error enables are.
- R11: A short-period error pulses `drive_errbit` for an owned, non-broadcast frame. For a broadcast frame it does so only when both `listen_all`=0 and `cfg_bcast_quiet`=0.
- R12: Error pulses arriving while no frame is accepted (after reset, or after `frame_end` and before the next header) produce no output.
- R13: The initiator nibble `hdr_byte[7:4]` has no effect on any decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hdr_valid | input | 1 | One-cycle pulse: header byte present on `hdr_byte` |
| hdr_byte | input | 8 | Header: initiator in [7:4], destination in [3:0] |
| frame_end | input | 1 | One-cycle pulse: current frame has ended |
| own_mask | input | 15 | Bit d set means logical address d is owned |
| listen_all | input | 1 | 1 = full listening mode, 0 = reduced |
| cfg_stop_on_rise | input | 1 | A rising error ends the reception |
| cfg_rise_errbit | input | 1 | Error bit on rising error (owned frames) |
| cfg_long_errbit | input | 1 | Error bit on long-period error (owned frames) |
| cfg_bcast_quiet | input | 1 | Suppress error bits on broadcast frames |
| err_rise | input | 1 | Bit-rising error pulse |
| err_short | input | 1 | Short-period error pulse |
| err_long | input | 1 | Long-period error pulse |
| accept | output | 1 | Current frame is being taken in |
| drive_ack | output | 1 | Drive a positive acknowledge for this frame |
| drive_errbit | output | 1 | One-cycle request to drive an error bit |
| stop_rx | output | 1 | One-cycle request to end the reception |

## Verification
Every result is registered once. `accept` and `drive_ack` change at the first clock edge that sees `hdr_valid` or `frame_end`. `drive_errbit` and `stop_rx` are one-cycle pulses at the first edge that sees an error pulse, and they fall again one edge later. The bench drives each stimulus for exactly one cycle from the falling edge. It samples at the next falling edge, which is half a period after the single register that can respond. Where a pulse must be brief, it samples once more a cycle later to confirm that the pulse has fallen.

// File: rtl/cec_pol_pkg.sv
package cec_pol_pkg;
  parameter int ADDR_W = 4;
  localparam int NUM_ADDR = 1 << ADDR_W;
  localparam int MASK_W = NUM_ADDR - 1;
  localparam logic [ADDR_W-1:0] BCAST_ADDR = ADDR_W'(NUM_ADDR - 1);

  typedef struct packed {
    logic stop_on_rise;
    logic rise_en;
    logic long_en;
    logic bcast_quiet;
  } err_cfg_t;

  typedef struct packed {
    logic rise;
    logic short_p;
    logic long_p;
  } err_pulse_t;
endpackage

// File: rtl/cec_dest_match.sv
module cec_dest_match
  import cec_pol_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int MW = (1 << AW) - 1
) (
  input  logic [AW-1:0] dest,
  input  logic [MW-1:0] mask,
  output logic          owned,
  output logic          bcast
);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  logic [MW-1:0] hit_vec;

  genvar gi;
  generate
    for (gi = 0; gi < MW; gi++) begin : g_slot
      assign hit_vec[gi] = mask[gi] && (dest == AW'(gi));
    end
  endgenerate

  assign owned = |hit_vec;
  assign bcast = (dest == ALL_ONES);
endmodule

// File: rtl/cec_errbit_policy.sv
module cec_errbit_policy
  import cec_pol_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_live,
  input  logic       frame_owned,
  input  logic       frame_bcast,
  input  logic       listen_all,
  input  err_cfg_t   cfg,
  input  err_pulse_t errs,
  output logic       stop_now,
  output logic       errbit_q,
  output logic       stop_q
);
  logic rise_bit, long_bit, short_bit;

  always_comb begin
    stop_now = frame_live && errs.rise && cfg.stop_on_rise;
    if (frame_bcast) begin
      rise_bit  = stop_now && !cfg.bcast_quiet;
      long_bit  = frame_live && errs.long_p && !cfg.bcast_quiet;
      short_bit = frame_live && errs.short_p && !listen_all && !cfg.bcast_quiet;
    end else begin
      rise_bit  = stop_now && frame_owned && cfg.rise_en;
      long_bit  = frame_live && errs.long_p && frame_owned && cfg.long_en;
      short_bit = frame_live && errs.short_p && frame_owned;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      errbit_q <= 1'b0;
      stop_q   <= 1'b0;
    end else begin
      errbit_q <= rise_bit || long_bit || short_bit;
      stop_q   <= stop_now;
    end
  end

  assert_stop_needs_cfg_R7: assert property (@(posedge clk) disable iff (rst)
    stop_q |-> $past(cfg.stop_on_rise) && $past(errs.rise));

  assert_errbit_has_cause_R12: assert property (@(posedge clk) disable iff (rst)
    errbit_q |-> $past(frame_live) && $past(errs.rise || errs.short_p || errs.long_p));

  assert_bystander_quiet_R5: assert property (@(posedge clk) disable iff (rst)
    errbit_q |-> $past(frame_owned || frame_bcast));

  assert_long_never_stops_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(errs.long_p) && !$past(errs.rise)) |-> !stop_q);
endmodule

// File: rtl/cec_rx_policy.sv
module cec_rx_policy
  import cec_pol_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              hdr_valid,
  input  logic [7:0]        hdr_byte,
  input  logic              frame_end,
  input  logic [MASK_W-1:0] own_mask,
  input  logic              listen_all,
  input  logic              cfg_stop_on_rise,
  input  logic              cfg_rise_errbit,
  input  logic              cfg_long_errbit,
  input  logic              cfg_bcast_quiet,
  input  logic              err_rise,
  input  logic              err_short,
  input  logic              err_long,
  output logic              accept,
  output logic              drive_ack,
  output logic              drive_errbit,
  output logic              stop_rx
);
  logic       hit_owned, hit_bcast;
  logic       accept_q, ack_q, owned_q, bcast_q;
  logic       stop_now;
  err_cfg_t   cfg;
  err_pulse_t errs;

  assign cfg  = '{stop_on_rise: cfg_stop_on_rise, rise_en: cfg_rise_errbit,
                  long_en: cfg_long_errbit, bcast_quiet: cfg_bcast_quiet};
  assign errs = '{rise: err_rise, short_p: err_short, long_p: err_long};

  cec_dest_match #(.AW(ADDR_W), .MW(MASK_W)) u_match (
    .dest  (hdr_byte[ADDR_W-1:0]),
    .mask  (own_mask),
    .owned (hit_owned),
    .bcast (hit_bcast)
  );

  cec_errbit_policy u_policy (
    .clk         (clk),
    .rst         (rst),
    .frame_live  (accept_q),
    .frame_owned (owned_q),
    .frame_bcast (bcast_q),
    .listen_all  (listen_all),
    .cfg         (cfg),
    .errs        (errs),
    .stop_now    (stop_now),
    .errbit_q    (drive_errbit),
    .stop_q      (stop_rx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      accept_q <= 1'b0;
      ack_q    <= 1'b0;
      owned_q  <= 1'b0;
      bcast_q  <= 1'b0;
    end else if (hdr_valid) begin
      accept_q <= hit_owned || hit_bcast || listen_all;
      ack_q    <= hit_owned && !hit_bcast;
      owned_q  <= hit_owned;
      bcast_q  <= hit_bcast;
    end else if (frame_end || stop_now) begin
      accept_q <= 1'b0;
      ack_q    <= 1'b0;
      owned_q  <= 1'b0;
      bcast_q  <= 1'b0;
    end
  end

  assign accept    = accept_q;
  assign drive_ack = ack_q;

  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !accept && !drive_ack && !drive_errbit && !stop_rx);

  assert_ack_needs_accept_R2: assert property (@(posedge clk) disable iff (rst)
    drive_ack |-> accept);

  assert_bcast_taken_unacked_R3: assert property (@(posedge clk) disable iff (rst)
    $past(hdr_valid && (hdr_byte[ADDR_W-1:0] == BCAST_ADDR)) |-> accept && !drive_ack);

  assert_end_clears_R6: assert property (@(posedge clk) disable iff (rst)
    $past(frame_end && !hdr_valid) |-> !accept && !drive_ack);

  assert_stop_drops_accept_R7: assert property (@(posedge clk) disable iff (rst)
    (stop_rx && !$past(hdr_valid)) |-> !accept);
endmodule

// File: tb/cec_rx_policy_test.sv
module cec_rx_policy_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic hdr_valid = 0, frame_end = 0;
  logic [7:0] hdr_byte = 8'h00;
  logic [14:0] own_mask = '0;
  logic listen_all = 0;
  logic cfg_stop_on_rise = 0, cfg_rise_errbit = 0, cfg_long_errbit = 0, cfg_bcast_quiet = 0;
  logic err_rise = 0, err_short = 0, err_long = 0;
  logic accept, drive_ack, drive_errbit, stop_rx;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cec_rx_policy uut (
    .clk(clk), .rst(rst), .hdr_valid(hdr_valid), .hdr_byte(hdr_byte),
    .frame_end(frame_end), .own_mask(own_mask), .listen_all(listen_all),
    .cfg_stop_on_rise(cfg_stop_on_rise), .cfg_rise_errbit(cfg_rise_errbit),
    .cfg_long_errbit(cfg_long_errbit), .cfg_bcast_quiet(cfg_bcast_quiet),
    .err_rise(err_rise), .err_short(err_short), .err_long(err_long),
    .accept(accept), .drive_ack(drive_ack), .drive_errbit(drive_errbit),
    .stop_rx(stop_rx)
  );

  task automatic check(input string tag, input logic got, input logic exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  task automatic send_hdr(input logic [7:0] b);
    @(negedge clk); hdr_valid = 1'b1; hdr_byte = b;
    @(negedge clk); hdr_valid = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk); frame_end = 1'b1;
    @(negedge clk); frame_end = 1'b0;
  endtask

  task automatic pulse_err(input logic r, input logic s, input logic l);
    @(negedge clk); err_rise = r; err_short = s; err_long = l;
    @(negedge clk); err_rise = 0; err_short = 0; err_long = 0;
  endtask

  task automatic set_cfg(input logic st, input logic re, input logic le, input logic bq);
    cfg_stop_on_rise = st; cfg_rise_errbit = re; cfg_long_errbit = le; cfg_bcast_quiet = bq;
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 accept", accept, 0);
    check("R1 drive_ack", drive_ack, 0);
    check("R1 drive_errbit", drive_errbit, 0);
    check("R1 stop_rx", stop_rx, 0);
  endtask

  task automatic t_owned();
    own_mask = 15'h0208; listen_all = 0; set_cfg(0, 0, 0, 0);
    send_hdr(8'h43);
    check("R2 accept dest3", accept, 1);
    check("R2 ack dest3", drive_ack, 1);
    repeat (3) @(negedge clk);
    check("R6 accept held", accept, 1);
    check("R6 ack held", drive_ack, 1);
    end_frame();
    check("R6 accept after end", accept, 0);
    check("R6 ack after end", drive_ack, 0);
    send_hdr(8'hA9);
    check("R13 accept dest9 initiator A", accept, 1);
    check("R13 ack dest9 initiator A", drive_ack, 1);
    end_frame();
    send_hdr(8'h99);
    check("R13 accept dest9 initiator 9", accept, 1);
    end_frame();
  endtask

  task automatic t_bcast();
    own_mask = '0; listen_all = 0;
    send_hdr(8'h5F);
    check("R3 bcast accept reduced", accept, 1);
    check("R3 bcast no ack", drive_ack, 0);
    end_frame();
    own_mask = 15'h7FFF; listen_all = 1;
    send_hdr(8'h0F);
    check("R3 bcast accept full", accept, 1);
    check("R3 bcast no ack full", drive_ack, 0);
    end_frame();
  endtask

  task automatic t_reduced_other();
    own_mask = 15'h0008; listen_all = 0; set_cfg(1, 1, 1, 0);
    send_hdr(8'h45);
    check("R4 unowned not accepted", accept, 0);
    check("R4 unowned no ack", drive_ack, 0);
    pulse_err(1, 1, 1);
    check("R4 no errbit", drive_errbit, 0);
    check("R4 no stop", stop_rx, 0);
    end_frame();
  endtask

  task automatic t_full_other();
    own_mask = 15'h0008; listen_all = 1; set_cfg(1, 1, 1, 0);
    send_hdr(8'h45);
    check("R5 unowned accepted", accept, 1);
    check("R5 unowned no ack", drive_ack, 0);
    pulse_err(0, 1, 1);
    check("R5 no errbit short/long", drive_errbit, 0);
    pulse_err(1, 0, 0);
    check("R5 no errbit rise", drive_errbit, 0);
    check("R7 stop on bystander frame", stop_rx, 1);
    check("R7 accept dropped", accept, 0);
    end_frame();
  endtask

  task automatic t_rise();
    own_mask = 15'h0010; listen_all = 0;
    set_cfg(0, 1, 0, 0);
    send_hdr(8'h14);
    pulse_err(1, 0, 0);
    check("R7 no stop when cfg clear", stop_rx, 0);
    check("R8 no errbit without stop cfg", drive_errbit, 0);
    check("R7 accept kept", accept, 1);
    set_cfg(1, 0, 0, 0);
    pulse_err(1, 0, 0);
    check("R7 stop pulse", stop_rx, 1);
    check("R7 accept cleared", accept, 0);
    check("R8 no errbit enable clear", drive_errbit, 0);
    @(negedge clk);
    check("R7 stop one cycle", stop_rx, 0);
    set_cfg(1, 1, 0, 0);
    send_hdr(8'h14);
    pulse_err(1, 0, 0);
    check("R8 errbit both set", drive_errbit, 1);
    check("R8 stop with errbit", stop_rx, 1);
    @(negedge clk);
    check("R8 errbit one cycle", drive_errbit, 0);
    end_frame();
  endtask

  task automatic t_long();
    own_mask = 15'h0001; listen_all = 0; set_cfg(1, 1, 0, 0);
    send_hdr(8'h30);
    pulse_err(0, 0, 1);
    check("R9 no errbit enable clear", drive_errbit, 0);
    cfg_long_errbit = 1;
    pulse_err(0, 0, 1);
    check("R9 errbit enable set", drive_errbit, 1);
    check("R9 no stop", stop_rx, 0);
    check("R9 accept kept", accept, 1);
    end_frame();
  endtask

  task automatic t_bcast_err();
    own_mask = '0; listen_all = 0; set_cfg(1, 0, 0, 0);
    send_hdr(8'h2F);
    pulse_err(0, 0, 1);
    check("R10 bcast long errbit enables clear", drive_errbit, 1);
    pulse_err(1, 0, 0);
    check("R10 bcast rise errbit enables clear", drive_errbit, 1);
    check("R10 bcast rise stop", stop_rx, 1);
    set_cfg(1, 1, 1, 1);
    send_hdr(8'h2F);
    pulse_err(0, 0, 1);
    check("R10 bcast long quiet", drive_errbit, 0);
    pulse_err(1, 0, 0);
    check("R10 bcast rise quiet", drive_errbit, 0);
    check("R10 bcast rise quiet still stops", stop_rx, 1);
    end_frame();
  endtask

  task automatic t_short();
    own_mask = 15'h0004; listen_all = 0; set_cfg(0, 0, 0, 0);
    send_hdr(8'h12);
    pulse_err(0, 1, 0);
    check("R11 short owned", drive_errbit, 1);
    end_frame();
    listen_all = 1;
    send_hdr(8'h1F);
    pulse_err(0, 1, 0);
    check("R11 short bcast full listen", drive_errbit, 0);
    end_frame();
    listen_all = 0;
    send_hdr(8'h1F);
    pulse_err(0, 1, 0);
    check("R11 short bcast reduced", drive_errbit, 1);
    cfg_bcast_quiet = 1;
    pulse_err(0, 1, 0);
    check("R11 short bcast quiet", drive_errbit, 0);
    end_frame();
  endtask

  task automatic t_idle();
    own_mask = 15'h7FFF; listen_all = 1; set_cfg(1, 1, 1, 0);
    pulse_err(1, 1, 1);
    check("R12 idle no errbit", drive_errbit, 0);
    check("R12 idle no stop", stop_rx, 0);
    check("R12 idle no accept", accept, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_owned();
    t_bcast();
    t_reduced_other();
    t_full_other();
    t_rise();
    t_long();
    t_bcast_err();
    t_short();
    t_idle();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule